// File: doc/BRIEF.md
# Frame Boundary Lock Detector

This receive-side block watches a recovered serial bit stream, one bit per clock, and finds where the 12-bit frames start. Each frame is a start bit of 1, ten data bits and a stop bit of 0. The stop-to-start edge (a 0 followed by a 1) therefore marks the frame boundary. The block keeps a free-running 12-bit word phase. In every word period it records at which of the 12 phases such an edge occurred. It declares lock once a single phase has shown the edge in enough consecutive words.

When locked, the block slices the ten data bits out of each frame, presents them on a parallel bus and raises a one-cycle word strobe. The lock flag is active low. An output-enable flag is high only while locked. When unlocked, the data bus and the strobe are held at zero, which corresponds to a high-impedance state at the pads. A repetitive pattern that shows the edge at several phases holds off lock. Once locked, only the edge at the locked phase matters. Analog clock and data recovery and the reference-clock loop are not part of this block.

Top module: `fbl_lock_detect`

## Requirements
- R1: After synchronous reset: lock_n_o=1, out_en_o=0, data_o=0 and word_stb_o=0. The word phase is 0, and the previous-bit register holds 1, so the first bit after reset cannot form an edge.
- R2: While hunting, lock is declared at the end of the word in which one phase completes LOCK_HITS (4) consecutive words with a 0-to-1 edge, provided no other phase has done so. lock_n_o changes only at the clock edge that closes a word (phase 11).
- R3: If two or more phases have each shown the edge in their last LOCK_HITS words, lock is withheld. Lock is taken at the first word end at which only one such phase remains.
- R4: Once locked, extra edges at other phases (a repetitive multi-transition pattern) do not affect lock, as long as the locked phase shows its edge.
- R5: Once locked, a word without the edge at the locked phase counts as a miss, and a word with it clears the miss count. Lock is dropped at the end of the LOSS_MISSES-th (4th) consecutive miss.
- R6: When lock is dropped, all per-phase edge histories are cleared. A new boundary must show its edge in LOCK_HITS fresh words after the drop before lock returns, even if it was already present before the drop.
- R7: While locked at phase L, the word is captured on the clock edge of the bit at phase (L+10) mod 12. data_o bit 0 is the first data bit after the start bit and bit 9 is the last. word_stb_o is high for that one cycle, once per word.
- R8: While unlocked, data_o is 0 and word_stb_o stays low. The data register restarts from 0 on every new lock.
- R9: out_en_o is the inverse of lock_n_o: high exactly while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Recovered serial data bit |
| lock_n_o | output | 1 | Lock flag, low while locked |
| out_en_o | output | 1 | High while data_o and word_stb_o are valid |
| data_o | output | 10 | Aligned data word, first received data bit in bit 0 |
| word_stb_o | output | 1 | One-cycle strobe per captured word |

## Verification
The bench uses the defaults LOCK_HITS=4 and LOSS_MISSES=4. With these values, lock gain, the three-miss survival and the fourth-miss drop each fall a handful of word periods after a directed pattern, so the exact word end of each can be checked. The short hit window also means random frame data sometimes repeats an edge at a data phase for four words. The random slip phase therefore also produces ambiguity holds and relocks at new phases, beside the directed sync burst, the two-phase hunt pattern and the slipped boundary.

// File: rtl/fbl_pkg.sv
package fbl_pkg;

    localparam int FRAME_W = 12;
    localparam int DATA_W  = FRAME_W - 2;
    localparam int POS_W   = $clog2(FRAME_W);

    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [FRAME_W-1:0] pos_mask_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    // per-bit view of the stream produced by the window stage
    typedef struct packed {
        pos_t      phase;
        logic      word_end;
        pos_mask_t hits;
    } bit_view_t;

    // lock result produced by the tracker
    typedef struct packed {
        logic locked;
        pos_t pos;
    } lock_view_t;

    function automatic int popcount(pos_mask_t m);
        int n;
        n = 0;
        for (int i = 0; i < FRAME_W; i++) n += int'(m[i]);
        return n;
    endfunction

    // lowest set position of a mask
    function automatic pos_t mask_to_pos(pos_mask_t m);
        pos_t r;
        r = '0;
        for (int i = FRAME_W - 1; i >= 0; i--) begin
            if (m[i]) r = pos_t'(i);
        end
        return r;
    endfunction

    function automatic pos_t pos_advance(pos_t p, int k);
        return pos_t'((int'(p) + k) % FRAME_W);
    endfunction

    // first received data bit lands in bit 0
    function automatic word_t reverse_word(word_t w);
        word_t r;
        for (int i = 0; i < DATA_W; i++) r[i] = w[DATA_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/fbl_bit_window.sv
module fbl_bit_window
    import fbl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_bit,
    output bit_view_t view_o,
    output word_t     recent_o
);

    pos_t      ph_q;
    logic      prev_q;
    pos_mask_t hits_q;
    word_t     hist_q;

    logic      edge_now;
    logic      word_end;
    pos_mask_t hits_now;

    always_comb begin
        edge_now = !prev_q && rx_bit;
        word_end = (ph_q == pos_t'(FRAME_W - 1));
        hits_now = hits_q | (edge_now ? (pos_mask_t'(1) << ph_q) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            prev_q <= 1'b1;
            hits_q <= '0;
            hist_q <= '0;
        end else begin
            ph_q   <= word_end ? '0 : ph_q + 1'b1;
            prev_q <= rx_bit;
            hits_q <= word_end ? '0 : hits_now;
            hist_q <= {hist_q[DATA_W-2:0], rx_bit};
        end
    end

    assign view_o   = '{phase: ph_q, word_end: word_end, hits: hits_now};
    assign recent_o = {hist_q[DATA_W-2:0], rx_bit};

endmodule

// File: rtl/fbl_lock_tracker.sv
module fbl_lock_tracker
    import fbl_pkg::*;
#(
    parameter int LOCK_HITS   = 4,
    parameter int LOSS_MISSES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word_end_i,
    input  pos_mask_t  hits_i,
    output lock_view_t lock_o
);

    localparam int SW = $clog2(LOCK_HITS + 1);
    localparam int MW = $clog2(LOSS_MISSES + 1);

    lock_state_t    state_q;
    pos_t           pos_q;
    logic [MW-1:0]  miss_q;
    logic [MW-1:0]  miss_nx;
    pos_mask_t      full_mask;
    logic           hit_locked;
    logic           drop_now;
    logic           gain_now;

    always_comb begin
        hit_locked = hits_i[pos_q];
        miss_nx    = miss_q + 1'b1;
        drop_now   = (state_q == ST_LOCKED) && !hit_locked && (miss_nx == MW'(LOSS_MISSES));
        gain_now   = (state_q == ST_HUNT) && (popcount(full_mask) == 1);
    end

    // one consecutive-hit history per phase
    for (genvar p = 0; p < FRAME_W; p++) begin : g_phase
        logic [SW-1:0] cnt_q;
        logic [SW-1:0] cnt_nx;

        always_comb begin
            if (!hits_i[p])                      cnt_nx = '0;
            else if (cnt_q == SW'(LOCK_HITS))    cnt_nx = cnt_q;
            else                                 cnt_nx = cnt_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst)             cnt_q <= '0;
            else if (word_end_i) cnt_q <= drop_now ? '0 : cnt_nx;
        end

        assign full_mask[p] = (cnt_nx == SW'(LOCK_HITS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            miss_q  <= '0;
        end else if (word_end_i) begin
            case (state_q)
                ST_HUNT: begin
                    if (gain_now) begin
                        state_q <= ST_LOCKED;
                        pos_q   <= mask_to_pos(full_mask);
                        miss_q  <= '0;
                    end
                end
                default: begin
                    if (hit_locked) begin
                        miss_q <= '0;
                    end else if (drop_now) begin
                        state_q <= ST_HUNT;
                        miss_q  <= '0;
                    end else begin
                        miss_q <= miss_nx;
                    end
                end
            endcase
        end
    end

    assign lock_o = '{locked: (state_q == ST_LOCKED), pos: pos_q};

    // R2: lock state moves only on the edge closing a word
    p_lock_word_end_r2: assert property (@(posedge clk) disable iff (rst)
        !word_end_i |=> $stable(state_q));

    // R4: locked phase does not wander while lock is held
    p_pos_held_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED) && $past(state_q == ST_LOCKED) |-> $stable(pos_q));

    // R5: a lock drop follows the last allowed miss
    p_drop_after_misses_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $fell(state_q == ST_LOCKED) |-> $past(miss_q) == MW'(LOSS_MISSES - 1));

endmodule

// File: rtl/fbl_word_unpack.sv
module fbl_word_unpack
    import fbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lock_view_t lock_i,
    input  pos_t       phase_i,
    input  word_t      recent_i,
    output word_t      data_o,
    output logic       stb_o
);

    word_t data_q;
    logic  stb_q;
    logic  capture;

    always_comb begin
        capture = lock_i.locked && (phase_i == pos_advance(lock_i.pos, DATA_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            stb_q  <= 1'b0;
        end else if (!lock_i.locked) begin
            data_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= capture;
            if (capture) data_q <= reverse_word(recent_i);
        end
    end

    assign data_o = lock_i.locked ? data_q : '0;
    assign stb_o  = stb_q && lock_i.locked;

    // R7: at most one strobe per word, never back to back
    p_stb_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    // R8: a strobe is only raised from a locked state
    p_stb_needs_lock_r8: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> $past(lock_i.locked));

endmodule

// File: rtl/fbl_lock_detect.sv
module fbl_lock_detect
    import fbl_pkg::*;
#(
    parameter int LOCK_HITS   = 4,
    parameter int LOSS_MISSES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    output logic              lock_n_o,
    output logic              out_en_o,
    output logic [DATA_W-1:0] data_o,
    output logic              word_stb_o
);

    bit_view_t  view;
    word_t      recent;
    lock_view_t lock;

    fbl_bit_window u_window (
        .clk      (clk),
        .rst      (rst),
        .rx_bit   (rx_bit),
        .view_o   (view),
        .recent_o (recent)
    );

    fbl_lock_tracker #(
        .LOCK_HITS   (LOCK_HITS),
        .LOSS_MISSES (LOSS_MISSES)
    ) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .word_end_i (view.word_end),
        .hits_i     (view.hits),
        .lock_o     (lock)
    );

    fbl_word_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .lock_i   (lock),
        .phase_i  (view.phase),
        .recent_i (recent),
        .data_o   (data_o),
        .stb_o    (word_stb_o)
    );

    assign lock_n_o = !lock.locked;
    assign out_en_o = lock.locked;

endmodule

// File: tb/sim_fbl_lock_detect.sv
`timescale 1ns/1ps
module sim_fbl_lock_detect;

    localparam int HITS   = 4;
    localparam int MISSES = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       lock_n_o, out_en_o, word_stb_o;
    logic [9:0] data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fbl_lock_detect #(.LOCK_HITS(HITS), .LOSS_MISSES(MISSES)) u0 (
        .clk(clk), .rst(rst), .rx_bit(rx_bit),
        .lock_n_o(lock_n_o), .out_en_o(out_en_o),
        .data_o(data_o), .word_stb_o(word_stb_o)
    );

    // reference model state
    int       m_ph, m_pos, m_miss;
    int       m_str[12];
    bit       m_prev, m_lock, m_stb;
    bit [11:0] m_acc;
    bit [9:0]  m_hist, m_data;

    logic [9:0] last_word;
    int         stb_seen;

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_prev = 1'b1; m_acc = '0; m_lock = 1'b0; m_pos = 0;
        m_miss = 0; m_hist = '0; m_data = '0; m_stb = 1'b0;
        for (int p = 0; p < 12; p++) m_str[p] = 0;
    endtask

    task automatic model_step(bit b);
        bit        t;
        bit        old;
        bit [11:0] accn;
        int        full;
        int        fpos;
        t = !m_prev && b;
        old = m_lock;
        accn = m_acc;
        if (t) accn[m_ph] = 1'b1;
        m_hist = {m_hist[8:0], b};
        if (!old) begin
            m_data = '0; m_stb = 1'b0;
        end else if (m_ph == (m_pos + 10) % 12) begin
            for (int i = 0; i < 10; i++) m_data[i] = m_hist[9-i];
            m_stb = 1'b1;
        end else begin
            m_stb = 1'b0;
        end
        if (m_ph == 11) begin
            for (int p = 0; p < 12; p++)
                m_str[p] = accn[p] ? ((m_str[p] < HITS) ? m_str[p] + 1 : HITS) : 0;
            if (m_lock) begin
                if (accn[m_pos]) m_miss = 0;
                else begin
                    m_miss++;
                    if (m_miss == MISSES) begin
                        m_lock = 1'b0; m_miss = 0;
                        for (int p = 0; p < 12; p++) m_str[p] = 0;
                    end
                end
            end else begin
                full = 0; fpos = 0;
                for (int p = 11; p >= 0; p--) if (m_str[p] == HITS) begin full++; fpos = p; end
                if (full == 1) begin m_lock = 1'b1; m_pos = fpos; m_miss = 0; end
            end
            m_acc = '0;
        end else begin
            m_acc = accn;
        end
        m_prev = b;
        m_ph = (m_ph + 1) % 12;
    endtask

    task automatic send_bit(bit b);
        rx_bit = b;
        @(posedge clk);
        model_step(b);
        #1;
        check("R2", "lock_n", int'(lock_n_o), int'(!m_lock));
        check("R9", "out_en", int'(out_en_o), int'(m_lock));
        check("R7", "data", int'(data_o), m_lock ? int'(m_data) : 0);
        check("R7", "strobe", int'(word_stb_o), int'(m_stb && m_lock));
        if (word_stb_o) begin
            last_word = data_o;
            stb_seen++;
        end
    endtask

    // bits[0] goes out first
    task automatic send_word(logic [11:0] bits);
        for (int i = 0; i < 12; i++) send_bit(bits[i]);
    endtask

    task automatic send_frame(logic [9:0] d);
        send_word({1'b0, d, 1'b1});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_bit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        check("R1", "lock_n after reset", int'(lock_n_o), 1);
        check("R1", "out_en after reset", int'(out_en_o), 0);
        check("R1", "data after reset", int'(data_o), 0);
        check("R1", "strobe after reset", int'(word_stb_o), 0);
    endtask

    localparam logic [11:0] W_SYNC  = 12'h03F; // six ones then six zeros
    localparam logic [11:0] W_TWO   = 12'h041; // edges at phases 0 and 6
    localparam logic [11:0] W_SLIP5 = 12'h3E0; // edge at phase 5 only
    localparam logic [11:0] W_ZERO  = 12'h000;

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [9:0] d;
        void'($urandom(32'd20240611));
        stb_seen = 0;
        last_word = '0;
        model_reset();

        // hunt with two repeating edge phases: lock withheld
        do_reset();
        send_word(W_ZERO);
        for (int k = 0; k < 8; k++) send_word(W_TWO);
        check("R3", "lock_n during ambiguous pattern", int'(lock_n_o), 1);
        send_word(W_SYNC);
        check("R3", "lock_n once phase 6 drops out", int'(lock_n_o), 0);

        // reset mid-lock, then sync burst: lock at end of fifth word
        do_reset();
        for (int k = 0; k < 4; k++) send_word(W_SYNC);
        check("R2", "lock_n after four sync words", int'(lock_n_o), 1);
        send_word(W_SYNC);
        check("R2", "lock_n after fifth sync word", int'(lock_n_o), 0);
        check("R9", "out_en when locked", int'(out_en_o), 1);
        send_word(W_SYNC);

        // random frames at phase 0
        for (int k = 0; k < 20; k++) begin
            d = 10'($urandom);
            send_frame(d);
            check("R7", "captured word", int'(last_word), int'(d));
        end

        // repeating multi-edge data after lock
        for (int k = 0; k < 8; k++) send_frame(10'h2AA);
        check("R4", "lock_n under multi-edge frames", int'(lock_n_o), 0);
        check("R4", "captured multi-edge word", int'(last_word), 10'h2AA);

        // three misses then a hit: lock kept
        for (int k = 0; k < 3; k++) send_word(W_ZERO);
        check("R5", "lock_n after three misses", int'(lock_n_o), 0);
        send_frame(10'h155);
        check("R5", "lock_n after recovering hit", int'(lock_n_o), 0);

        // slipped boundary at phase 5: four misses drop lock
        for (int k = 0; k < 3; k++) send_word(W_SLIP5);
        check("R5", "lock_n after third slipped word", int'(lock_n_o), 0);
        send_word(W_SLIP5);
        check("R5", "lock_n after fourth miss", int'(lock_n_o), 1);
        check("R8", "out_en when unlocked", int'(out_en_o), 0);
        check("R8", "data when unlocked", int'(data_o), 0);

        // relock needs four fresh words
        stb_seen = 0;
        for (int k = 0; k < 3; k++) begin
            send_word(W_SLIP5);
            check("R6", "lock_n before fresh history", int'(lock_n_o), 1);
        end
        check("R8", "strobes while unlocked", stb_seen, 0);
        send_word(W_SLIP5);
        check("R6", "lock_n after four fresh words", int'(lock_n_o), 0);

        // frames aligned to phase 5
        for (int k = 0; k < 5; k++) send_bit(1'b0);
        for (int k = 0; k < 20; k++) begin
            d = 10'($urandom);
            send_frame(d);
            check("R7", "captured word at phase 5", int'(last_word), int'(d));
        end

        // random slips, sync bursts and noise against the model
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = int'($urandom % 4);
            for (int j = 0; j < int'($urandom % 12); j++) send_bit(1'($urandom));
            if (sel == 0) begin
                for (int j = 0; j < 6; j++) send_word(W_SYNC);
            end else if (sel == 1) begin
                send_word(12'($urandom));
            end else begin
                for (int j = 0; j < 2 + int'($urandom % 8); j++) send_frame(10'($urandom));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule